// File: doc/BRIEF.md
# SDRAM Clock and Power-Down Control

This block keeps two software-controlled bits for one SDRAM device. The first bit lets the SDRAM clock output run or holds it off. The second bit sets the level of the SDRAM clock-enable pin. A write to either bit does more than change a level: when the clock-enable bit actually changes while the clock is running, the block sends a power-down entry or power-down exit request to the SDRAM command sequencer that follows it. The block also gives that sequencer two inhibit flags. One blocks all automatic command transitions. The other blocks automatic mode-register-set and read commands.

After reset, both bits take their value from a boot-select input. They come up set when the boot memory is synchronous and clear when it is not. Software then changes the bits through a one-cycle write strobe that carries a 2-bit control field. Every output comes from a register or from registered state, so the sequencer sees each write take effect in the cycle after the write edge.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: While `rstN` is low, `sdClkRun` and `sdCke` both equal `bootSync` (1 for a synchronous boot memory, 0 otherwise). `pdEnterReq` and `pdExitReq` are 0.
- R2: A write (`wrEn`=1 at a rising clock edge) loads `wrCtl[1]` into the clock-run bit and `wrCtl[0]` into the clock-enable bit. `sdClkRun` and `sdCke` show the new values in the cycle after that edge and hold them while no write occurs.
- R3: A write that changes the clock-enable bit from 1 to 0 while the written clock-run value is 1 raises `pdEnterReq` for exactly the cycle after the write edge.
- R4: A write that changes the clock-enable bit from 0 to 1 while the written clock-run value is 1 raises `pdExitReq` for exactly the cycle after the write edge. This includes a write that sets both bits at once.
- R5: Rewriting the clock-enable bit with its current value produces no power-down request.
- R6: A write whose clock-run value is 0 produces no power-down request. `sdCke` still follows the written clock-enable value.
- R7: `autoCmdInhibit` is 1 exactly while `sdClkRun` is 0.
- R8: `mrsReadInhibit` is 1 while `sdCke` is 0 or `sdClkRun` is 0, and 0 otherwise.
- R9: `pdEnterReq` and `pdExitReq` are never 1 in the same cycle. Each pulse lasts one cycle, even when writes arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rstN | input | 1 | Active-low asynchronous reset, used for hardware and sleep reset |
| bootSync | input | 1 | 1 when the boot memory is a synchronous type |
| wrEn | input | 1 | One-cycle write strobe for the control field |
| wrCtl | input | 2 | Bit 1: clock-run value; bit 0: clock-enable value |
| sdClkRun | output | 1 | Gate for the SDRAM clock output (1 = running) |
| sdCke | output | 1 | SDRAM clock-enable pin level |
| pdEnterReq | output | 1 | One-cycle power-down entry request to the sequencer |
| pdExitReq | output | 1 | One-cycle power-down exit request to the sequencer |
| autoCmdInhibit | output | 1 | Blocks all automatic command transitions |
| mrsReadInhibit | output | 1 | Blocks automatic mode-register-set and read commands |

## Verification
The write path is driven with field values chosen so that each kind of change occurs: a falling clock-enable, a rising clock-enable, a rewrite of the same value, changes made while the clock is stopped, and a single write that starts the clock and raises clock-enable together. These patterns separate a design that issues requests on real transitions from one that issues them on every write, and they also reveal which clock-run value (the old one or the new one) gates the request. Both boot-select values are applied during reset. Two writes on consecutive cycles show that the pulses stay one cycle long and never overlap.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  localparam int unsigned CTL_W   = 2;
  localparam int unsigned RUN_POS = 1;
  localparam int unsigned CKE_POS = 0;

  typedef struct packed {
    logic load;
    logic nextRun;
    logic nextCke;
    logic enterPd;
    logic exitPd;
  } pdStrobes_t;
endpackage

// File: rtl/sdram_pd_ctl.sv
module sdram_pd_ctl
  import sdram_pd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrCtl,
  input  logic             curCke,
  output pdStrobes_t       stb
);
  logic newRun, newCke;

  assign newRun = wrCtl[RUN_POS];
  assign newCke = wrCtl[CKE_POS];

  always_comb begin
    stb         = '0;
    stb.load    = wrEn;
    stb.nextRun = newRun;
    stb.nextCke = newCke;
    // requests only on a real change, gated by the clock-run value being written
    stb.enterPd = wrEn && newRun && curCke && !newCke;
    stb.exitPd  = wrEn && newRun && !curCke && newCke;
  end

  // R9: the two requests are mutually exclusive at decode time
  p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enterPd && stb.exitPd));

  // R6: a stopped clock never yields a request strobe
  p_no_req_stopped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrCtl[RUN_POS]) |-> !(stb.enterPd || stb.exitPd));
endmodule

// File: rtl/sdram_pd_dp.sv
module sdram_pd_dp
  import sdram_pd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bootSync,
  input  pdStrobes_t stb,
  output logic       runBit,
  output logic       ckeBit,
  output logic       enterPulse,
  output logic       exitPulse,
  output logic       allInhibit,
  output logic       mrsRdInhibit
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit     <= bootSync;
      ckeBit     <= bootSync;
      enterPulse <= 1'b0;
      exitPulse  <= 1'b0;
    end else begin
      enterPulse <= stb.enterPd;
      exitPulse  <= stb.exitPd;
      if (stb.load) begin
        runBit <= stb.nextRun;
        ckeBit <= stb.nextCke;
      end
    end
  end

  always_comb begin
    allInhibit   = !runBit;
    mrsRdInhibit = !runBit || !ckeBit;
  end

  // R3: an entry request always follows a clock-enable that was high
  p_enter_from_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    enterPulse |-> (runBit && !ckeBit && $past(ckeBit)));

  // R4: an exit request always follows a clock-enable that was low
  p_exit_from_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> (runBit && ckeBit && !$past(ckeBit)));

  // R9: pulses last one cycle
  p_enter_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    enterPulse |=> !enterPulse);
  p_exit_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |=> !exitPulse);

  // R2: the bits hold without a write
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(runBit) && $stable(ckeBit)));
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootSync,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrCtl,
  output logic             sdClkRun,
  output logic             sdCke,
  output logic             pdEnterReq,
  output logic             pdExitReq,
  output logic             autoCmdInhibit,
  output logic             mrsReadInhibit
);
  pdStrobes_t stb;

  sdram_pd_ctl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrCtl  (wrCtl),
    .curCke (sdCke),
    .stb    (stb)
  );

  sdram_pd_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .bootSync     (bootSync),
    .stb          (stb),
    .runBit       (sdClkRun),
    .ckeBit       (sdCke),
    .enterPulse   (pdEnterReq),
    .exitPulse    (pdExitReq),
    .allInhibit   (autoCmdInhibit),
    .mrsRdInhibit (mrsReadInhibit)
  );

  // R1: no request can leave the block while it is held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> !(pdEnterReq || pdExitReq));
endmodule

// File: tb/tb_sdram_pd_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_pd_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootSync = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrCtl = 2'b00;
  logic sdClkRun, sdCke, pdEnterReq, pdExitReq, autoCmdInhibit, mrsReadInhibit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_pd_ctrl dut (
    .clk(clk), .rstN(rstN), .bootSync(bootSync), .wrEn(wrEn), .wrCtl(wrCtl),
    .sdClkRun(sdClkRun), .sdCke(sdCke), .pdEnterReq(pdEnterReq), .pdExitReq(pdExitReq),
    .autoCmdInhibit(autoCmdInhibit), .mrsReadInhibit(mrsReadInhibit)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic run, input logic cke,
                        input logic enter, input logic exitP);
    chk(req, "sdClkRun", sdClkRun, run);
    chk(req, "sdCke", sdCke, cke);
    chk(req, "pdEnterReq", pdEnterReq, enter);
    chk(req, "pdExitReq", pdExitReq, exitP);
    chk("R7", "autoCmdInhibit", autoCmdInhibit, !run);
    chk("R8", "mrsReadInhibit", mrsReadInhibit, !run || !cke);
  endtask

  // one-cycle write; returns at the negedge after the write edge
  task automatic doWrite(input logic [1:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrCtl = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset(input logic boot);
    @(negedge clk);
    rstN = 1'b0;
    bootSync = boot;
    @(negedge clk);
    chkAll("R1", boot, boot, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkAll("R1", boot, boot, 1'b0, 1'b0);
  endtask

  task automatic testEnter();
    doWrite(2'b10);
    chkAll("R3", 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chkAll("R9", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testExit();
    doWrite(2'b11);
    chkAll("R4", 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chkAll("R9", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testRewrite();
    doWrite(2'b11);
    chkAll("R5", 1'b1, 1'b1, 1'b0, 1'b0);
    doWrite(2'b10);
    chkAll("R3", 1'b1, 1'b0, 1'b1, 1'b0);
    doWrite(2'b10);
    chkAll("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    doWrite(2'b11);
    chkAll("R4", 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testStopped();
    doWrite(2'b01);
    chkAll("R6", 1'b0, 1'b1, 1'b0, 1'b0);
    doWrite(2'b00);
    chkAll("R6", 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chkAll("R2", 1'b0, 1'b0, 1'b0, 1'b0);
    doWrite(2'b01);
    chkAll("R6", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testJointStart();
    doWrite(2'b00);
    chkAll("R2", 1'b0, 1'b0, 1'b0, 1'b0);
    doWrite(2'b11);
    chkAll("R4", 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    wrEn = 1'b1;
    wrCtl = 2'b10;
    @(negedge clk);
    chkAll("R9", 1'b1, 1'b0, 1'b1, 1'b0);
    wrCtl = 2'b11;
    @(negedge clk);
    wrEn = 1'b0;
    chkAll("R9", 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chkAll("R9", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    testReset(1'b0);
    testReset(1'b1);
    testEnter();
    testExit();
    testRewrite();
    testStopped();
    testJointStart();
    testBackToBack();
    testReset(1'b0);
    doWrite(2'b11);
    chkAll("R4", 1'b1, 1'b1, 1'b0, 1'b1);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule